// File: doc/BRIEF.md
# YCbCr to RGB Pixel Converter

This block turns a stream of already-aligned luma/chroma triplets into packed RGB pixels. Each pixel arrives on a valid/ready input with one luma sample and one blue-difference and one red-difference chroma sample. It leaves on a valid/ready output as a 24-bit word. The conversion first removes the black level from luma and the mid-scale offset from each chroma sample. It then multiplies by five shared fixed-point coefficients, sums, rounds to nearest, saturates each channel to 8 bits and packs the channels in one of three layouts.

The coefficients are programmed through a small write port that has an index and a value. Reset loads a limited-range default set. Software can overwrite it with any other set, for example a full-range one. The packing layout is sampled together with each pixel, so pixels in different layouts can follow each other in the stream. The datapath has three register stages and each stage has its own handshake. A stalled output therefore never loses or repeats a pixel.

Top module: `ycbcr_rgb_conv`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the coefficients are K0=0x4A8, K1=0x662, K2=0x191, K3=0x341, K4=0x811. With these values a pixel (Y=235, Cb=128, Cr=128) in 888 layout yields 0xFFFFFF.
- R2: Red = K0·(Y−16) + K1·(Cr−128).
- R3: Green = K0·(Y−16) − K2·(Cb−128) − K3·(Cr−128). Both chroma terms are subtracted.
- R4: Blue = K0·(Y−16) + K4·(Cb−128). K0 is shared by all three channels.
- R5: Coefficients are unsigned with 10 fractional bits. Each channel sum has 512 added and is shifted right arithmetically by 10. The result is then saturated to the range 0 to 255.
- R6: fmt_sel is captured with each accepted pixel. Code 0 selects 555, code 1 selects 565, and codes 2 and 3 select 888.
- R7: Red sits in the most significant position. In 555 layout out_rgb = {9'b0, R[7:3], G[7:3], B[7:3]}. In 565 layout out_rgb = {8'b0, R[7:3], G[7:2], B[7:3]}. In 888 layout out_rgb = {R, G, B}.
- R8: With the output not stalled, a pixel accepted on one rising edge is shown on out_valid after the second rising edge that follows it (three register stages).
- R9: Pixels leave in acceptance order, with none dropped and none duplicated. While out_valid is 1 and out_ready is 0, out_valid and out_rgb hold their values.
- R10: A write with cfg_we=1 stores cfg_data into coefficient Kn, where n = cfg_idx and n is 0 to 4. Writes with cfg_idx 5, 6 or 7 change nothing.
- R11: A coefficient write applies only to pixels accepted on later edges. A pixel accepted on the same edge as the write, and any pixel already in flight, uses the old value.
- R12: in_ready is 1 whenever out_ready is 1. in_ready is 0 only when all three stages are full and the output is stalled, so a fully stalled pipeline accepts exactly three pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | 3 | Coefficient index (0..4 valid) |
| cfg_data | input | 12 | Coefficient value, 10 fractional bits |
| fmt_sel | input | 2 | Output layout code for the pixel being accepted |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Converter can accept a pixel |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_rgb | output | 24 | Packed RGB pixel, zero-extended |

## Verification
Some properties are checked on every cycle. These are the handshake rules: a stalled output and the middle stage hold their contents, in_ready drops only when the whole pipeline is full and stalled, and a coefficient write either lands in the addressed register or leaves every register untouched when the index is a spare one. The arithmetic can only be shown by the bench's scenarios, which compare every delivered pixel against an independent model. This covers the sign of the green chroma terms, the rounding and saturation, and the three packing layouts. The same holds for the exact three-stage latency and for write ordering, where pixels in flight across a coefficient change must still carry the old values.

// File: rtl/csc_pkg.sv
// Shared types and reset constants for the colour-space converter.
// Assumes coefficients of at most 12 bits with 10 fractional bits.
package csc_pkg;

    localparam int unsigned NUM_COEF = 5;

    // Output packing layout, captured with each pixel.
    typedef enum logic [1:0] {
        PK_555     = 2'd0,
        PK_565     = 2'd1,
        PK_888     = 2'd2,
        PK_888_ALT = 2'd3
    } pack_e;

    // Reset value of coefficient idx (limited-range conversion set).
    function automatic logic [11:0] coef_reset(input int idx);
        case (idx)
            0:       return 12'h4A8;
            1:       return 12'h662;
            2:       return 12'h191;
            3:       return 12'h341;
            default: return 12'h811;
        endcase
    endfunction

endpackage

// File: rtl/csc_coef_bank.sv
// Coefficient register bank.
// Holds NUM coefficients loaded from reset constants and overwritten by an
// indexed write. Indices at or above NUM are ignored.
module csc_coef_bank #(
    parameter int COEF_W = 12,
    parameter int NUM    = 5,
    parameter int IDX_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [COEF_W-1:0]          wr_val,
    output logic [NUM-1:0][COEF_W-1:0] coef
);

    // Reset to defaults, otherwise update the addressed entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM; i++) begin
            if (!rst_n) begin
                coef[i] <= COEF_W'(csc_pkg::coef_reset(i));
            end else if (wr_en && (int'(wr_idx) == i)) begin
                coef[i] <= wr_val;
            end
        end
    end

    AST_SPARE_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) >= NUM) |=> $stable(coef)); // R10

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) < NUM) |=> (coef[$past(wr_idx)] == $past(wr_val))); // R10

endmodule

// File: rtl/csc_mac_pipe.sv
// Offset removal, multiply and accumulate: pipeline stages one and two.
// Stage one registers the five products using the coefficients live on the
// accepting edge. Stage two forms the three signed channel sums.
// Each stage may accept when it is empty or when its successor takes its data.
module csc_mac_pipe #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 12,
    parameter int NUM    = 5,
    parameter int ACC_W  = 25
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       up_valid,
    output logic                       up_ready,
    input  logic [PIX_W-1:0]           y,
    input  logic [PIX_W-1:0]           cb,
    input  logic [PIX_W-1:0]           cr,
    input  csc_pkg::pack_e             fmt,
    input  logic [NUM-1:0][COEF_W-1:0] coef,
    output logic                       dn_valid,
    input  logic                       dn_ready,
    output logic signed [ACC_W-1:0]    sum_r,
    output logic signed [ACC_W-1:0]    sum_g,
    output logic signed [ACC_W-1:0]    sum_b,
    output csc_pkg::pack_e             dn_fmt
);

    localparam int DIFF_W = PIX_W + 1;
    localparam int PROD_W = COEF_W + DIFF_W + 1;
    localparam int Y_OFS  = 2 ** (PIX_W - 4);
    localparam int C_OFS  = 2 ** (PIX_W - 1);

    // Signed product of an unsigned coefficient and a signed difference.
    function automatic logic signed [PROD_W-1:0] mul(
        input logic [COEF_W-1:0]        c,
        input logic signed [DIFF_W-1:0] d
    );
        logic signed [PROD_W-1:0] cs;
        logic signed [PROD_W-1:0] ds;
        cs = signed'(PROD_W'({1'b0, c}));
        ds = PROD_W'(d);
        return cs * ds;
    endfunction

    logic signed [DIFF_W-1:0] y_d, cb_d, cr_d;
    logic                     v1, v2, rdy1, rdy2;
    logic signed [PROD_W-1:0] m_y, m_rv, m_gu, m_gv, m_bu;
    csc_pkg::pack_e           f1;

    // Remove black level from luma and mid-scale from chroma.
    always_comb begin
        y_d  = signed'({1'b0, y})  - signed'(DIFF_W'(Y_OFS));
        cb_d = signed'({1'b0, cb}) - signed'(DIFF_W'(C_OFS));
        cr_d = signed'({1'b0, cr}) - signed'(DIFF_W'(C_OFS));
    end

    assign rdy2     = !v2 || dn_ready;
    assign rdy1     = !v1 || rdy2;
    assign up_ready = rdy1;
    assign dn_valid = v2;

    // Stage one occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)    v1 <= 1'b0;
        else if (rdy1) v1 <= up_valid;
    end

    // Stage one products, formed with the coefficients of the accepting edge.
    always_ff @(posedge clk) begin
        if (rdy1 && up_valid) begin
            m_y  <= mul(coef[0], y_d);
            m_rv <= mul(coef[1], cr_d);
            m_gu <= mul(coef[2], cb_d);
            m_gv <= mul(coef[3], cr_d);
            m_bu <= mul(coef[4], cb_d);
            f1   <= fmt;
        end
    end

    // Stage two occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)    v2 <= 1'b0;
        else if (rdy2) v2 <= v1;
    end

    // Stage two channel sums; the green chroma terms are subtracted.
    always_ff @(posedge clk) begin
        if (rdy2 && v1) begin
            sum_r  <= ACC_W'(m_y) + ACC_W'(m_rv);
            sum_g  <= ACC_W'(m_y) - ACC_W'(m_gu) - ACC_W'(m_gv);
            sum_b  <= ACC_W'(m_y) + ACC_W'(m_bu);
            dn_fmt <= f1;
        end
    end

    AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && !dn_ready) |=> (v2 && $stable(sum_r) && $stable(sum_g) && $stable(sum_b))); // R9

endmodule

// File: rtl/csc_round_pack.sv
// Round, saturate and pack: pipeline stage three.
// Adds half an LSB, shifts out FRAC bits, saturates each channel to PIX_W
// bits and packs the channels in the layout carried with the pixel.
// Assumes 3*PIX_W >= 16 so that the narrow layouts fit.
module csc_round_pack #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 25,
    parameter int FRAC  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     up_valid,
    output logic                     up_ready,
    input  logic signed [ACC_W-1:0]  sum_r,
    input  logic signed [ACC_W-1:0]  sum_g,
    input  logic signed [ACC_W-1:0]  sum_b,
    input  csc_pkg::pack_e           fmt,
    output logic                     dn_valid,
    input  logic                     dn_ready,
    output logic [3*PIX_W-1:0]       rgb
);

    localparam int RGB_W = 3 * PIX_W;
    localparam int HALF  = 2 ** (FRAC - 1);
    localparam int MAXV  = 2 ** PIX_W - 1;

    logic signed [ACC_W-1:0]    sums [3];
    logic [2:0][PIX_W-1:0]      chan;
    logic [RGB_W-1:0]           packed_w;
    logic                       v3, rdy3;

    assign sums[0] = sum_r;
    assign sums[1] = sum_g;
    assign sums[2] = sum_b;

    // Saturate a rounded value to the channel range.
    function automatic logic [PIX_W-1:0] sat(input logic signed [ACC_W-1:0] v);
        if (v < 0)                               return '0;
        else if (v > signed'(ACC_W'(MAXV)))      return '1;
        else                                     return v[PIX_W-1:0];
    endfunction

    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        logic signed [ACC_W-1:0] rnd;
        assign rnd                 = (sums[ch] + signed'(ACC_W'(HALF))) >>> FRAC;
        assign chan[2-ch]          = sat(rnd);
    end

    // Select the packing layout for this pixel; red is most significant.
    always_comb begin
        case (fmt)
            csc_pkg::PK_555: packed_w = RGB_W'({chan[2][PIX_W-1 -: 5],
                                                chan[1][PIX_W-1 -: 5],
                                                chan[0][PIX_W-1 -: 5]});
            csc_pkg::PK_565: packed_w = RGB_W'({chan[2][PIX_W-1 -: 5],
                                                chan[1][PIX_W-1 -: 6],
                                                chan[0][PIX_W-1 -: 5]});
            default:         packed_w = {chan[2], chan[1], chan[0]};
        endcase
    end

    assign rdy3     = !v3 || dn_ready;
    assign up_ready = rdy3;
    assign dn_valid = v3;

    // Output stage occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)    v3 <= 1'b0;
        else if (rdy3) v3 <= up_valid;
    end

    // Output register, loaded only when the stage moves.
    always_ff @(posedge clk) begin
        if (rdy3 && up_valid) rgb <= packed_w;
    end

endmodule

// File: rtl/ycbcr_rgb_conv.sv
// YCbCr to RGB converter top level.
// Connects the coefficient bank, the multiply/accumulate stages and the
// round/pack stage. Input triplets are assumed already aligned; the output
// layout code travels with each pixel.
module ycbcr_rgb_conv #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 12,
    parameter int FRAC   = 10,
    parameter int IDX_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [COEF_W-1:0]    cfg_data,
    input  logic [1:0]           fmt_sel,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PIX_W-1:0]     in_y,
    input  logic [PIX_W-1:0]     in_cb,
    input  logic [PIX_W-1:0]     in_cr,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [3*PIX_W-1:0]   out_rgb
);

    localparam int NUM   = csc_pkg::NUM_COEF;
    localparam int ACC_W = COEF_W + PIX_W + 4;

    logic [NUM-1:0][COEF_W-1:0] coef;
    logic                       mid_valid, mid_ready;
    logic signed [ACC_W-1:0]    s_r, s_g, s_b;
    csc_pkg::pack_e             mid_fmt;

    csc_coef_bank #(.COEF_W(COEF_W), .NUM(NUM), .IDX_W(IDX_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_val (cfg_data),
        .coef   (coef)
    );

    csc_mac_pipe #(.PIX_W(PIX_W), .COEF_W(COEF_W), .NUM(NUM), .ACC_W(ACC_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .y        (in_y),
        .cb       (in_cb),
        .cr       (in_cr),
        .fmt      (csc_pkg::pack_e'(fmt_sel)),
        .coef     (coef),
        .dn_valid (mid_valid),
        .dn_ready (mid_ready),
        .sum_r    (s_r),
        .sum_g    (s_g),
        .sum_b    (s_b),
        .dn_fmt   (mid_fmt)
    );

    csc_round_pack #(.PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (mid_valid),
        .up_ready (mid_ready),
        .sum_r    (s_r),
        .sum_g    (s_g),
        .sum_b    (s_b),
        .fmt      (mid_fmt),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .rgb      (out_rgb)
    );

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb))); // R9

    AST_READY_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready && mid_valid)); // R12

endmodule

// File: tb/ycbcr_rgb_conv_tb.sv
`timescale 1ns/1ps
module ycbcr_rgb_conv_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [11:0] cfg_data;
    logic [1:0]  fmt_sel;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_y, in_cb, in_cr;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_rgb;

    always #4 clk = ~clk;

    ycbcr_rgb_conv u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .fmt_sel(fmt_sel), .in_valid(in_valid),
        .in_ready(in_ready), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
    );

    int          total = 0;
    int          bad   = 0;
    int          mc [5];
    logic [23:0] expq [$];
    bit          hold_pend = 1'b0;
    logic [23:0] held;
    int          acc_cnt;
    bit          finished = 1'b0;
    string       phase = "R2 R3 R4 R5";

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int sat8(input int v);
        if (v < 0)   return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // Reference conversion from the requirements, using the model coefficients.
    function automatic logic [23:0] ref_pix(input int y, input int cb, input int cr, input int f);
        int yd, cbd, crd, r, g, b, w;
        yd  = y - 16;
        cbd = cb - 128;
        crd = cr - 128;
        r = sat8((mc[0] * yd + mc[1] * crd + 512) >>> 10);
        g = sat8((mc[0] * yd - mc[2] * cbd - mc[3] * crd + 512) >>> 10);
        b = sat8((mc[0] * yd + mc[4] * cbd + 512) >>> 10);
        if (f == 0)      w = ((r >> 3) << 10) | ((g >> 3) << 5) | (b >> 3);
        else if (f == 1) w = ((r >> 3) << 11) | ((g >> 2) << 5) | (b >> 3);
        else             w = (r << 16) | (g << 8) | b;
        return 24'(w);
    endfunction

    // One clock: check outputs, update the model, then advance to the next falling edge.
    task automatic tick();
        logic [23:0] e;
        #1;
        if (hold_pend)
            check(out_valid === 1'b1 && out_rgb === held, "R9 stalled output held", out_rgb, held);
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 extra pixel delivered", out_rgb, 24'h0);
            end else begin
                e = expq.pop_front();
                check(out_rgb === e, {phase, " pixel value"}, out_rgb, e);
            end
        end
        hold_pend = out_valid && !out_ready;
        held      = out_rgb;
        if (in_valid && in_ready) begin
            expq.push_back(ref_pix(int'(in_y), int'(in_cb), int'(in_cr), int'(fmt_sel)));
            acc_cnt++;
        end
        if (cfg_we && cfg_idx < 3'd5) mc[cfg_idx] = int'(cfg_data);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rand_pix(input bit v);
        in_valid = v;
        in_y     = 8'($urandom);
        in_cb    = 8'($urandom);
        in_cr    = 8'($urandom);
        fmt_sel  = 2'($urandom_range(3, 0));
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0; fmt_sel = 2'd2;
        in_valid = 1'b0; in_y = '0; in_cb = '0; in_cr = '0; out_ready = 1'b1;
        for (int i = 0; i < 5; i++) mc[i] = int'(12'h4A8);
        mc[1] = 'h662; mc[2] = 'h191; mc[3] = 'h341; mc[4] = 'h811;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid === 1'b0, "R1 out_valid after reset", 24'(out_valid), 24'h0);
        check(in_ready === 1'b1, "R1 in_ready after reset", 24'(in_ready), 24'h1);
        @(negedge clk);

        // R8 latency and R1 default coefficients: white in 888 layout.
        phase = "R1";
        in_valid = 1'b1; in_y = 8'd235; in_cb = 8'd128; in_cr = 8'd128; fmt_sel = 2'd2;
        tick();
        in_valid = 1'b0;
        begin
            int n = 1;
            while (!out_valid && n < 10) begin
                tick();
                n++;
            end
            check(n == 3, "R8 latency in cycles", 24'(n), 24'd3);
            check(out_rgb === 24'hFFFFFF, "R1 default coefficients white", out_rgb, 24'hFFFFFF);
        end
        tick();

        // R2 R3 R4 R5: corner triplets in every layout code.
        phase = "R2 R3 R4 R5 corners";
        for (int f = 0; f < 4; f++) begin
            for (int k = 0; k < 6; k++) begin
                in_valid = 1'b1;
                fmt_sel  = 2'(f);
                case (k)
                    0: begin in_y = 8'd0;   in_cb = 8'd0;   in_cr = 8'd0;   end
                    1: begin in_y = 8'd255; in_cb = 8'd255; in_cr = 8'd255; end
                    2: begin in_y = 8'd0;   in_cb = 8'd255; in_cr = 8'd0;   end
                    3: begin in_y = 8'd255; in_cb = 8'd0;   in_cr = 8'd255; end
                    4: begin in_y = 8'd16;  in_cb = 8'd128; in_cr = 8'd128; end
                    default: begin in_y = 8'd81; in_cb = 8'd90; in_cr = 8'd240; end
                endcase
                tick();
            end
        end

        // R6 R7 R12: full-throughput random stream with mixed layouts.
        phase = "R6 R7 layouts";
        for (int i = 0; i < 200; i++) begin
            rand_pix(1'b1);
            #1;
            check(in_ready === 1'b1, "R12 ready with output open", 24'(in_ready), 24'h1);
            #0;
            tick_after_sample();
        end

        // R9: random valid and random backpressure.
        phase = "R9 backpressure";
        for (int i = 0; i < 400; i++) begin
            rand_pix($urandom_range(9, 0) < 7);
            out_ready = $urandom_range(1, 0) == 1;
            tick();
        end

        // R9 R12: fully stalled output accepts exactly three pixels.
        out_ready = 1'b0;
        for (int i = 0; i < 6; i++) begin
            rand_pix(1'b1);
            if (i == 0) acc_cnt = 0;
            tick();
        end
        check(acc_cnt == 3 || (acc_cnt < 3 && hold_pend), "R12 pixels accepted while stalled", 24'(acc_cnt), 24'd3);
        check(in_ready === 1'b0, "R12 ready low when full", 24'(in_ready), 24'h0);
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (6) tick();

        // R10 R11: load the full-range set while pixels stream and stall.
        phase = "R10 R11 coefficient writes";
        for (int i = 0; i < 5; i++) begin
            rand_pix(1'b1);
            out_ready = $urandom_range(1, 0) == 1;
            cfg_we = 1'b1; cfg_idx = 3'(i);
            case (i)
                0: cfg_data = 12'h400;
                1: cfg_data = 12'h59C;
                2: cfg_data = 12'h161;
                3: cfg_data = 12'h2DC;
                default: cfg_data = 12'h718;
            endcase
            tick();
        end
        cfg_we = 1'b0;
        for (int i = 0; i < 100; i++) begin
            rand_pix($urandom_range(3, 0) != 0);
            out_ready = $urandom_range(3, 0) != 0;
            tick();
        end

        // R10: spare indices must not change any coefficient.
        phase = "R10 spare index ignored";
        for (int i = 5; i < 8; i++) begin
            rand_pix(1'b1);
            cfg_we = 1'b1; cfg_idx = 3'(i); cfg_data = 12'hFFF;
            tick();
        end
        cfg_we = 1'b0;
        for (int i = 0; i < 40; i++) begin
            rand_pix(1'b1);
            out_ready = 1'b1;
            tick();
        end

        // R11: fill the stalled pipeline, then change K0 and K4 with pixels in flight.
        phase = "R11 write ordering";
        out_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rand_pix(1'b1);
            tick();
        end
        cfg_we = 1'b1; cfg_idx = 3'd0; cfg_data = 12'h200;
        rand_pix(1'b1);
        out_ready = 1'b1;
        tick();
        cfg_idx = 3'd4; cfg_data = 12'hFFF;
        rand_pix(1'b1);
        tick();
        cfg_we = 1'b0;
        for (int i = 0; i < 30; i++) begin
            rand_pix(1'b1);
            out_ready = $urandom_range(1, 0) == 1;
            tick();
        end

        // Drain and confirm nothing was lost.
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (8) tick();
        check(expq.size() == 0, "R9 no pixel lost", 24'(expq.size()), 24'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Same as tick, entered after the 1 ns sampling delay already spent.
    task automatic tick_after_sample();
        logic [23:0] e;
        if (hold_pend)
            check(out_valid === 1'b1 && out_rgb === held, "R9 stalled output held", out_rgb, held);
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 extra pixel delivered", out_rgb, 24'h0);
            end else begin
                e = expq.pop_front();
                check(out_rgb === e, {phase, " pixel value"}, out_rgb, e);
            end
        end
        hold_pend = out_valid && !out_ready;
        held      = out_rgb;
        if (in_valid && in_ready) begin
            expq.push_back(ref_pix(int'(in_y), int'(in_cb), int'(in_cr), int'(fmt_sel)));
            acc_cnt++;
        end
        if (cfg_we && cfg_idx < 3'd5) mc[cfg_idx] = int'(cfg_data);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog expired act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule